// File: doc/BRIEF.md
# Frame-Synchronous Shadow Register Bank

This block is the control register file that sits between a serial configuration front end and a sensor timing engine. Each completed write arrives as a one-cycle strobe carrying an address and a 24-bit word. Most control addresses change the value seen by the timing logic on the next clock. A small, fixed set of addresses is double-buffered instead. A write to one of them lands in a pending slot, and the timing logic keeps using the old value until the next rising edge of the frame (vertical) sync. This way a timing change cannot take effect partway through a frame.

The frame sync input is asynchronous to the register clock. It passes through a synchroniser and an edge detector inside the block. A second class of write, marked by a bank-select input, is meant for the wider system and mode register banks. Those writes never wait for the frame edge: they are passed out on a registered strobe one cycle later, whatever their address. All control values are presented in parallel on one flat output vector.

Top module: `frame_shadow_regs`

## Requirements
- R1: On reset, every control register i shows the value (i * 0x010101) truncated to 24 bits, all pending flags are clear, and bank_we is 0. A sync-class write made before a reset is therefore never committed afterwards.
- R2: A control write (wr_bank=0) to an immediate-class address is visible on its slice of active_regs right after the clock edge that samples the strobe. Register i occupies bits [24*i+23 : 24*i].
- R3: Control addresses 0x08, 0x09, 0x10, 0x11 and 0x12 are frame-synchronous. A write to one of them leaves active_regs unchanged until a frame-sync rising edge.
- R4: When vsync_in rises, pending values are copied into active_regs at the third clock edge after the first edge that samples vsync_in high (two synchroniser stages, then the commit). A falling edge of vsync_in commits nothing.
- R5: If a synchronous register is written several times between frame edges, only the last value is committed.
- R6: A synchronous write sampled on the same edge as a commit is not part of that commit. The commit applies the earlier pending value, and the new write is applied at the following rising edge.
- R7: A write with wr_bank=1 appears on bank_we/bank_addr/bank_data one cycle after the strobe, even when the address is a synchronous one. It leaves active_regs untouched and creates nothing pending.
- R8: A control write whose address is 0x20 or above changes no register.
- R9: Holding vsync_in high commits only once. A synchronous write made while it stays high waits for the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_bank | input | 1 | 1 = system/mode bank write (forwarded), 0 = control write |
| wr_addr | input | 8 | Register address |
| wr_data | input | 24 | Write data |
| vsync_in | input | 1 | Asynchronous frame sync |
| active_regs | output | 768 | All 32 active control values, register i at [24*i +: 24] |
| bank_we | output | 1 | Forwarded bank write strobe |
| bank_addr | output | 8 | Forwarded bank address |
| bank_data | output | 24 | Forwarded bank data |

## Verification
The bench writes every one of the 32 control addresses. After each write it compares the whole register vector with a model, which tells an immediate address apart from a buffered one and catches writes that land in the wrong slot. Frame-sync pulses are checked at the cycle before the commit and at the commit cycle. They are also driven as a long high level with a late write and as a falling edge alone, which separates edge detection from level sensing. The remaining cases are a write placed on the exact commit cycle, repeated writes before one edge, bank-flagged writes to buffered addresses, out-of-range addresses, and a reset issued while a value is pending.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic {
    SLOT_IMMEDIATE = 1'b0,
    SLOT_FRAME     = 1'b1
  } slot_kind_e;

  // Reset value of control register idx: idx repeated in every byte.
  function automatic logic [31:0] reset_value(int unsigned idx);
    return 32'(idx * 32'h0001_0101 + idx * 32'h0000_0000);
  endfunction

endpackage

// File: rtl/fsr_vsync_edge.sv
module fsr_vsync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vsync_async,
  output logic vsync_rise
);
  // STAGES synchroniser flops plus one history flop for edge detection.
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else begin
      sr <= {sr[STAGES-1:0], vsync_async};
    end
  end

  assign vsync_rise = sr[STAGES-1] & ~sr[STAGES];

  // R4: a detected edge lasts exactly one cycle
  p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
    vsync_rise |=> !vsync_rise);

endmodule

// File: rtl/fsr_write_decode.sv
module fsr_write_decode #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                wr_en,
  input  logic                wr_bank,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_REGS-1:0] slot_hit
);
  logic ctrl_wr;
  assign ctrl_wr = wr_en & ~wr_bank;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    assign slot_hit[i] = ctrl_wr & (wr_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/fsr_slot.sv
module fsr_slot
  import fsr_pkg::*;
#(
  parameter int unsigned DATA_W    = 24,
  parameter logic [31:0] RESET_VAL = '0,
  parameter slot_kind_e  KIND      = SLOT_IMMEDIATE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic [DATA_W-1:0] active
);
  localparam logic [DATA_W-1:0] RV = RESET_VAL[DATA_W-1:0];

  if (KIND == SLOT_FRAME) begin : g_frame
    logic [DATA_W-1:0] pending;
    logic              pend_flag;

    always_ff @(posedge clk) begin
      if (rst) begin
        active    <= RV;
        pending   <= RV;
        pend_flag <= 1'b0;
      end else begin
        if (commit && pend_flag) begin
          active <= pending;
        end
        if (hit) begin
          pending   <= wr_data;
          pend_flag <= 1'b1;
        end else if (commit) begin
          pend_flag <= 1'b0;
        end
      end
    end

    // R3: a buffered write marks the slot pending
    p_hold_pending_r3: assert property (@(posedge clk) disable iff (rst)
      hit |=> pend_flag && pending == $past(wr_data));
    // R4: commit copies the pending word into the active value
    p_commit_copy_r4: assert property (@(posedge clk) disable iff (rst)
      (commit && pend_flag) |=> active == $past(pending));
    // R6: a write on the commit edge stays pending for the next edge
    p_same_cycle_held_r6: assert property (@(posedge clk) disable iff (rst)
      (commit && hit) |=> pend_flag);
    // R3: no frame edge, no change of the active value
    p_no_edge_stable_r3: assert property (@(posedge clk) disable iff (rst)
      !commit |=> $stable(active));
  end else begin : g_imm
    always_ff @(posedge clk) begin
      if (rst) begin
        active <= RV;
      end else if (hit) begin
        active <= wr_data;
      end
    end

    // R2: immediate write shows on the next cycle
    p_immediate_r2: assert property (@(posedge clk) disable iff (rst)
      hit |=> active == $past(wr_data));
    // R2: without a write the value holds
    p_imm_stable_r2: assert property (@(posedge clk) disable iff (rst)
      !hit |=> $stable(active));
  end

endmodule

// File: rtl/frame_shadow_regs.sv
module frame_shadow_regs
  import fsr_pkg::*;
#(
  parameter int unsigned           ADDR_W      = 8,
  parameter int unsigned           DATA_W      = 24,
  parameter int unsigned           NUM_REGS    = 32,
  parameter int unsigned           SYNC_STAGES = 2,
  parameter logic [NUM_REGS-1:0]   SYNC_MASK   = 32'h0007_0300
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic                         wr_bank,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         vsync_in,
  output logic [NUM_REGS*DATA_W-1:0]   active_regs,
  output logic                         bank_we,
  output logic [ADDR_W-1:0]            bank_addr,
  output logic [DATA_W-1:0]            bank_data
);
  localparam int unsigned FLAT_W = NUM_REGS * DATA_W;

  logic                vs_rise;
  logic [NUM_REGS-1:0] slot_hit;

  fsr_vsync_edge #(.STAGES(SYNC_STAGES)) u_vsync (
    .clk         (clk),
    .rst         (rst),
    .vsync_async (vsync_in),
    .vsync_rise  (vs_rise)
  );

  fsr_write_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_addr  (wr_addr),
    .slot_hit (slot_hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    fsr_slot #(
      .DATA_W    (DATA_W),
      .RESET_VAL (reset_value(i)),
      .KIND      (SYNC_MASK[i] ? SLOT_FRAME : SLOT_IMMEDIATE)
    ) u_slot (
      .clk     (clk),
      .rst     (rst),
      .hit     (slot_hit[i]),
      .wr_data (wr_data),
      .commit  (vs_rise),
      .active  (active_regs[i*DATA_W +: DATA_W])
    );
  end

  // System/mode bank writes bypass all buffering.
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_we   <= 1'b0;
      bank_addr <= '0;
      bank_data <= '0;
    end else begin
      bank_we <= wr_en & wr_bank;
      if (wr_en && wr_bank) begin
        bank_addr <= wr_addr;
        bank_data <= wr_data;
      end
    end
  end

  // R7: bank write forwarded one cycle later with its payload
  p_bank_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bank) |=> bank_we && bank_addr == $past(wr_addr)
                           && bank_data == $past(wr_data));
  // R7: bank write alone does not disturb the control file
  p_bank_isolated_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bank && !vs_rise) |=> $stable(active_regs));
  // R8: out-of-range control write changes nothing
  p_out_of_range_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_bank && wr_addr >= ADDR_W'(NUM_REGS) && !vs_rise)
      |=> $stable(active_regs));

  initial begin
    assert (FLAT_W == NUM_REGS * DATA_W && NUM_REGS <= (1 << ADDR_W))
      else $error("register count exceeds address space");
  end

endmodule

// File: tb/frame_shadow_regs_tb.sv
`timescale 1ns/1ps
module frame_shadow_regs_tb;
  localparam int NR = 32;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_bank = 1'b0, vsync_in = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NR*DW-1:0] active_regs;
  logic bank_we;
  logic [7:0] bank_addr;
  logic [DW-1:0] bank_data;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] expv [NR];
  logic [DW-1:0] pend [NR];
  bit            pflag [NR];

  always #10 clk = ~clk;

  frame_shadow_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .vsync_in(vsync_in),
    .active_regs(active_regs), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_data(bank_data));

  function automatic bit is_sync(int a);
    return a == 8 || a == 9 || a == 16 || a == 17 || a == 18;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < NR; i++) begin
      expv[i] = DW'(i * 32'h010101);
      pflag[i] = 0;
    end
  endfunction

  function automatic void model_write(int a, logic [DW-1:0] d);
    if (a < NR) begin
      if (is_sync(a)) begin pend[a] = d; pflag[a] = 1; end
      else expv[a] = d;
    end
  endfunction

  function automatic void model_commit();
    for (int i = 0; i < NR; i++)
      if (pflag[i]) begin expv[i] = pend[i]; pflag[i] = 0; end
  endfunction

  task automatic check_all(string tag);
    int bad = -1;
    for (int i = 0; i < NR; i++)
      if (bad < 0 && active_regs[i*DW +: DW] !== expv[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s reg %0d actual %h expected %h", tag, bad,
               active_regs[bad*DW +: DW], expv[bad]);
    end
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(int a, logic [DW-1:0] d, bit bank);
    @(negedge clk);
    wr_en = 1; wr_bank = bank; wr_addr = 8'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_bank = 0;
  endtask

  task automatic vsync_pulse();
    @(negedge clk); vsync_in = 1;
    repeat (3) @(negedge clk);
    vsync_in = 0;
    repeat (3) @(negedge clk);
    model_commit();
  endtask

  task automatic apply_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_all("R1 reset values");
    check_val("R1 bank_we idle", 32'(bank_we), 0);

    // R2: sweep all immediate addresses
    for (int a = 0; a < NR; a++) begin
      if (!is_sync(a)) begin
        do_write(a, DW'(24'hC00000 ^ (a * 24'h000777)), 0);
        model_write(a, DW'(24'hC00000 ^ (a * 24'h000777)));
        check_all("R2 immediate write");
      end
    end

    // R3: buffered addresses do not move
    for (int a = 0; a < NR; a++) begin
      if (is_sync(a)) begin
        do_write(a, DW'(24'h300000 + a), 0);
        model_write(a, DW'(24'h300000 + a));
        check_all("R3 buffered write held");
      end
    end

    // R5: overwrite pending value of 0x08
    do_write(8, 24'hABCDEF, 0);
    model_write(8, 24'hABCDEF);
    check_all("R5 overwrite held");

    // R4: commit timing
    @(negedge clk); vsync_in = 1;
    repeat (2) @(negedge clk);
    check_all("R4 not yet committed");
    @(negedge clk);
    model_commit();
    check_all("R4 committed on third edge");
    check_val("R5 last value wins", 32'(active_regs[8*DW +: DW]), 32'hABCDEF);
    vsync_in = 0;
    repeat (4) @(negedge clk);
    check_all("R4 falling edge no commit");

    // R9: level held high commits once
    do_write(9, 24'h123456, 0);
    model_write(9, 24'h123456);
    @(negedge clk); vsync_in = 1;
    repeat (3) @(negedge clk);
    model_commit();
    check_all("R9 first commit");
    do_write(9, 24'h654321, 0);
    model_write(9, 24'h654321);
    repeat (5) @(negedge clk);
    check_all("R9 held high no recommit");
    vsync_in = 0;
    repeat (4) @(negedge clk);
    check_all("R9 falling no commit");
    vsync_pulse();
    check_all("R9 next rise commits");

    // R6: write on the commit cycle
    do_write(16, 24'h0A0A0A, 0);
    model_write(16, 24'h0A0A0A);
    @(negedge clk); vsync_in = 1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1; wr_addr = 8'h10; wr_data = 24'h0B0B0B;
    @(negedge clk);
    wr_en = 0;
    model_commit();
    model_write(16, 24'h0B0B0B);
    check_all("R6 earlier pending committed");
    vsync_in = 0;
    repeat (4) @(negedge clk);
    check_all("R6 late write still pending");
    vsync_pulse();
    check_all("R6 late write committed next edge");

    // R7: bank writes bypass
    do_write(8, 24'h777777, 1);
    check_val("R7 bank_we", 32'(bank_we), 1);
    check_val("R7 bank_addr", 32'(bank_addr), 32'h08);
    check_val("R7 bank_data", 32'(bank_data), 32'h777777);
    check_all("R7 control file untouched");
    @(negedge clk);
    check_val("R7 bank_we one cycle", 32'(bank_we), 0);
    vsync_pulse();
    check_all("R7 nothing pending");

    // R8: out-of-range addresses
    do_write(8'h20, 24'hFFFFFF, 0);
    check_all("R8 addr 0x20 ignored");
    do_write(8'hFF, 24'h111111, 0);
    vsync_pulse();
    check_all("R8 addr 0xFF ignored");

    // R1: reset discards pending
    do_write(17, 24'hDEAD00, 0);
    apply_reset();
    @(negedge clk);
    check_all("R1 reset restores defaults");
    vsync_pulse();
    check_all("R1 pending cleared by reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule